// File: doc/BRIEF.md
# Flash Controller Interrupt Status Unit

This unit keeps the interrupt status word, the controller error word and the two system configuration words of a NAND-style flash controller. The command engine reports finished operations and error conditions as single-cycle strobes. The unit folds each strobe into the status words, drives the host interrupt pin and the ready pin, and lets the host read and clear the words over a simple register port. It also gates new commands. A write to the command register is passed on to the command decoder (`cmd_accept`) only while no interrupt is pending.

Commands are gated by a two-state machine. In GATE_SHUT the master interrupt flag is pending and command writes are dropped. In GATE_OPEN the flag is clear and a command write is accepted in the same cycle. The transition OPEN_TO_SHUT happens when the next master flag value is set. The transition SHUT_TO_OPEN happens when that value clears. A reset of either kind is a strobe input. The cold kind leaves load-done pending. The warm kind leaves reset-done pending. An active-low asynchronous `rst_n` behaves as a cold reset.

The host port uses these register indices. 0 is interrupt status. 1 is controller status, which the host can only read. 2 is configuration-1. 3 is configuration-2. 4 is the command register. Every other index reads as zero.

Top module: `flash_irq_status_unit`

## Requirements
- R1: After `rst_n` or a `cold_rst` strobe: interrupt status reads 0x8080, controller status 0, configuration-1 0x40C0, configuration-2 0, command 0, `rdy_o` is 1 and `irq_o` is 1. When both reset strobes arrive together, the cold values win.
- R2: A `warm_rst` strobe alone gives the same values as R1, except that interrupt status becomes 0x8010.
- R3: `ev_done[i]` sets interrupt status bit 15 and bit 4+i in the next cycle. The index mapping is 0 = reset done, 1 = erase done, 2 = program done, 3 = load done. Event bits are applied after any host AND in the same cycle.
- R4: `ev_err[j]` ORs controller status bit 10+j in the next cycle. The index mapping is 0 = command, 1 = erase, 2 = program, 3 = load.
- R5: A host write to index 0 ANDs the written data into interrupt status.
- R6: If that AND leaves bit 15 clear, controller status bits 10 to 13 are cleared. An error strobe in the same cycle still sets its bit. If bit 15 stays set, the error bits are kept.
- R7: `irq_o` is a register. It equals interrupt status bit 15 XOR NOT configuration-1 bit 6, both taken as they stood one cycle earlier.
- R8: A write to index 4 sets `cmd_accept` in the same cycle and stores the data, but only when interrupt status bit 15 is clear and no reset strobe is present. Otherwise the write is ignored and the command register keeps its value.
- R9: Configuration-1 reads back with bits 4:0 forced to zero. Configuration-2 reads back as written.
- R10: `rdy_o` takes bit 7 of each configuration-1 write one cycle later. Either reset sets it high.
- R11: Host writes to index 1 leave controller status unchanged. Index 5 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, cold values |
| cold_rst | input | 1 | Cold reset strobe |
| warm_rst | input | 1 | Warm or hot reset strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write register index |
| host_wdata | input | 16 | Host write data |
| rd_addr | input | 3 | Readback register index |
| ev_done | input | 4 | Done strobes: reset, erase, program, load |
| ev_err | input | 4 | Error strobes: command, erase, program, load |
| rd_data | output | 16 | Readback data, combinational |
| irq_o | output | 1 | Host interrupt pin, polarity from configuration-1 bit 6 |
| rdy_o | output | 1 | Ready pin |
| cmd_accept | output | 1 | Command write passed to the decoder |

## Verification
Directed sequences cover several cases. They write commands with the master flag pending and then clear, which separates a gate that tracks the registered flag from one that ignores it. They apply AND masks that keep bit 15 and masks that drop it, which shows whether error clearing depends on the post-AND master bit. Error strobes arrive in the same cycle as a clearing write, to settle the ordering. Both interrupt polarities and both reset kinds, alone and together, check the pin and reset values. A long run of random writes, strobes and reads is then compared on every clock against a behavioural model of the requirements.

// File: rtl/flash_isu_pkg.sv
package flash_isu_pkg;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 3;
    localparam int NUM_REGS   = 5;

    localparam int IDX_INT    = 0;
    localparam int IDX_STAT   = 1;
    localparam int IDX_CFG1   = 2;
    localparam int IDX_CFG2   = 3;
    localparam int IDX_CMD    = 4;

    localparam int MASTER_BIT = 15;
    localparam int DONE_BASE  = 4;
    localparam int N_DONE     = 4;
    localparam int ERR_BASE   = 10;
    localparam int N_ERR      = 4;
    localparam int POL_BIT    = 6;
    localparam int RDY_BIT    = 7;
    localparam int CFG1_HIDE  = 5;

    localparam logic [DATA_W-1:0] INT_COLD  = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM  = 16'h8010;
    localparam logic [DATA_W-1:0] CFG1_INIT = 16'h40C0;
    localparam logic [DATA_W-1:0] ERR_FIELD =
        DATA_W'(((1 << N_ERR) - 1) << ERR_BASE);
    localparam logic [DATA_W-1:0] CFG1_RMASK =
        ~DATA_W'((1 << CFG1_HIDE) - 1);

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_WARM = 2'd1,
        RK_COLD = 2'd2
    } rst_kind_e;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_SHUT = 1'b1
    } gate_state_e;
endpackage

// File: rtl/isu_host_decode.sv
module isu_host_decode
    import flash_isu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int NR = NUM_REGS
) (
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    output logic [NR-1:0] wr_sel
);
    for (genvar i = 0; i < NR; i++) begin : g_sel
        assign wr_sel[i] = host_wr && (host_addr == AW'(i));
    end
endmodule

// File: rtl/isu_status_regs.sv
module isu_status_regs
    import flash_isu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int ND = N_DONE,
    parameter int NE = N_ERR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_cold,
    input  logic          rst_warm,
    input  logic          wr_int,
    input  logic [DW-1:0] wdata,
    input  logic [ND-1:0] ev_done,
    input  logic [NE-1:0] ev_err,
    output logic [DW-1:0] int_q,
    output logic [DW-1:0] stat_q,
    output logic          master_nxt
);
    rst_kind_e     rk;
    logic [DW-1:0] int_and;
    logic [DW-1:0] done_mask;
    logic [DW-1:0] err_mask;
    logic [DW-1:0] int_d;
    logic [DW-1:0] stat_d;
    logic          clr_err;

    always_comb begin
        if (rst_cold)      rk = RK_COLD;
        else if (rst_warm) rk = RK_WARM;
        else               rk = RK_NONE;
    end

    always_comb begin
        done_mask = '0;
        for (int i = 0; i < ND; i++) begin
            done_mask[DONE_BASE + i] = ev_done[i];
        end
        if (|ev_done) done_mask[MASTER_BIT] = 1'b1;
        err_mask = '0;
        for (int j = 0; j < NE; j++) begin
            err_mask[ERR_BASE + j] = ev_err[j];
        end
    end

    always_comb begin
        int_and = wr_int ? (int_q & wdata) : int_q;
        clr_err = wr_int && !int_and[MASTER_BIT];
        unique case (rk)
            RK_COLD: begin
                int_d  = INT_COLD;
                stat_d = '0;
            end
            RK_WARM: begin
                int_d  = INT_WARM;
                stat_d = '0;
            end
            default: begin
                int_d  = int_and | done_mask;
                stat_d = (clr_err ? (stat_q & ~ERR_FIELD) : stat_q) | err_mask;
            end
        endcase
        master_nxt = int_d[MASTER_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q  <= INT_COLD;
            stat_q <= '0;
        end else begin
            int_q  <= int_d;
            stat_q <= stat_d;
        end
    end

    assert_done_sets_master_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|ev_done) && !rst_cold && !rst_warm) |=> int_q[MASTER_BIT]);

    assert_err_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err[0] && !rst_cold && !rst_warm) |=> stat_q[ERR_BASE]);

    assert_clear_errors_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_int && !wdata[MASTER_BIT] && (ev_err == '0) && !rst_cold && !rst_warm)
        |=> ((stat_q & ERR_FIELD) == '0));

    assert_warm_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_warm && !rst_cold) |=> (int_q == INT_WARM));
endmodule

// File: rtl/isu_config_regs.sv
module isu_config_regs
    import flash_isu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_any,
    input  logic          wr_cfg1,
    input  logic          wr_cfg2,
    input  logic          cmd_load,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cfg1_q,
    output logic [DW-1:0] cfg2_q,
    output logic [DW-1:0] cmd_q,
    output logic          rdy_q
);
    logic [DW-1:0] cfg1_d, cfg2_d, cmd_d;
    logic          rdy_d;

    always_comb begin
        cfg1_d = cfg1_q;
        cfg2_d = cfg2_q;
        cmd_d  = cmd_q;
        rdy_d  = rdy_q;
        if (rst_any) begin
            cfg1_d = CFG1_INIT;
            cfg2_d = '0;
            cmd_d  = '0;
            rdy_d  = 1'b1;
        end else begin
            if (wr_cfg1) begin
                cfg1_d = wdata;
                rdy_d  = wdata[RDY_BIT];
            end
            if (wr_cfg2)  cfg2_d = wdata;
            if (cmd_load) cmd_d  = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg1_q <= CFG1_INIT;
            cfg2_q <= '0;
            cmd_q  <= '0;
            rdy_q  <= 1'b1;
        end else begin
            cfg1_q <= cfg1_d;
            cfg2_q <= cfg2_d;
            cmd_q  <= cmd_d;
            rdy_q  <= rdy_d;
        end
    end

    assert_rdy_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg1 && !rst_any) |=> (rdy_q == $past(wdata[RDY_BIT])));

    assert_rdy_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_any |=> rdy_q);
endmodule

// File: rtl/isu_pin_drive.sv
module isu_pin_drive
    import flash_isu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_q,
    input  logic master_nxt,
    input  logic pol_bit,
    input  logic wr_cmd,
    input  logic rst_any,
    output logic cmd_accept,
    output logic irq_o
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OPEN: if (master_nxt)  state_d = GATE_SHUT;
            GATE_SHUT: if (!master_nxt) state_d = GATE_OPEN;
            default:                    state_d = GATE_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_SHUT;
        else        state_q <= state_d;
    end

    always_comb begin
        cmd_accept = (state_q == GATE_OPEN) && wr_cmd && !rst_any;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b1;
        else        irq_o <= master_q ^ ~pol_bit;
    end

    assert_gate_tracks_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == GATE_SHUT) == master_q));
endmodule

// File: rtl/flash_irq_status_unit.sv
module flash_irq_status_unit
    import flash_isu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cold_rst,
    input  logic              warm_rst,
    input  logic              host_wr,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    input  logic [AW-1:0]     rd_addr,
    input  logic [N_DONE-1:0] ev_done,
    input  logic [N_ERR-1:0]  ev_err,
    output logic [DW-1:0]     rd_data,
    output logic              irq_o,
    output logic              rdy_o,
    output logic              cmd_accept
);
    logic [NUM_REGS-1:0] wr_sel;
    logic [DW-1:0]       int_q, stat_q, cfg1_q, cfg2_q, cmd_q;
    logic                master_nxt;
    logic                rst_any;

    assign rst_any = cold_rst || warm_rst;

    isu_host_decode #(.AW(AW), .NR(NUM_REGS)) u_dec (
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .wr_sel    (wr_sel)
    );

    isu_status_regs #(.DW(DW), .ND(N_DONE), .NE(N_ERR)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .rst_cold   (cold_rst),
        .rst_warm   (warm_rst),
        .wr_int     (wr_sel[IDX_INT]),
        .wdata      (host_wdata),
        .ev_done    (ev_done),
        .ev_err     (ev_err),
        .int_q      (int_q),
        .stat_q     (stat_q),
        .master_nxt (master_nxt)
    );

    isu_config_regs #(.DW(DW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .rst_any  (rst_any),
        .wr_cfg1  (wr_sel[IDX_CFG1]),
        .wr_cfg2  (wr_sel[IDX_CFG2]),
        .cmd_load (cmd_accept),
        .wdata    (host_wdata),
        .cfg1_q   (cfg1_q),
        .cfg2_q   (cfg2_q),
        .cmd_q    (cmd_q),
        .rdy_q    (rdy_o)
    );

    isu_pin_drive u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_q   (int_q[MASTER_BIT]),
        .master_nxt (master_nxt),
        .pol_bit    (cfg1_q[POL_BIT]),
        .wr_cmd     (wr_sel[IDX_CMD]),
        .rst_any    (rst_any),
        .cmd_accept (cmd_accept),
        .irq_o      (irq_o)
    );

    always_comb begin
        case (rd_addr)
            AW'(IDX_INT):  rd_data = int_q;
            AW'(IDX_STAT): rd_data = stat_q;
            AW'(IDX_CFG1): rd_data = cfg1_q & CFG1_RMASK;
            AW'(IDX_CFG2): rd_data = cfg2_q;
            AW'(IDX_CMD):  rd_data = cmd_q;
            default:       rd_data = '0;
        endcase
    end

    assert_cmd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> !int_q[MASTER_BIT]);

    assert_stat_readonly_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[IDX_STAT] && (ev_err == '0) && !rst_any && !wr_sel[IDX_INT])
        |=> (stat_q == $past(stat_q)));
endmodule

// File: tb/sim_flash_irq_status_unit.sv
module sim_flash_irq_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cold_rst = 1'b0, warm_rst = 1'b0, host_wr = 1'b0;
    logic [2:0]  host_addr = '0, rd_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [3:0]  ev_done = '0, ev_err = '0;
    logic [15:0] rd_data;
    logic        irq_o, rdy_o, cmd_accept;

    int checks = 0;
    int bad = 0;

    always #10 clk = ~clk;

    flash_irq_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .cold_rst(cold_rst), .warm_rst(warm_rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .rd_addr(rd_addr), .ev_done(ev_done), .ev_err(ev_err),
        .rd_data(rd_data), .irq_o(irq_o), .rdy_o(rdy_o), .cmd_accept(cmd_accept)
    );

    // behavioural reference
    logic [15:0] m_int, m_stat, m_cfg1, m_cfg2, m_cmd;
    logic        m_rdy, m_irq;
    logic [15:0] t_int, t_stat;
    logic        t_irq, t_acc;

    function automatic logic m_accept();
        return host_wr && (host_addr == 3'd4) && !m_int[15] && !cold_rst && !warm_rst;
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_int;
            3'd1: return m_stat;
            3'd2: return m_cfg1 & 16'hFFE0;
            3'd3: return m_cfg2;
            3'd4: return m_cmd;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_int = 16'h8080; m_stat = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0;
            m_cmd = 0; m_rdy = 1'b1; m_irq = 1'b1;
        end else begin
            t_irq = m_int[15] ^ ~m_cfg1[6];
            t_acc = m_accept();
            if (cold_rst || warm_rst) begin
                m_int = cold_rst ? 16'h8080 : 16'h8010;
                m_stat = 0; m_cfg1 = 16'h40C0; m_cfg2 = 0; m_cmd = 0; m_rdy = 1'b1;
            end else begin
                t_int = (host_wr && host_addr == 3'd0) ? (m_int & host_wdata) : m_int;
                t_stat = m_stat;
                if (host_wr && host_addr == 3'd0 && !t_int[15]) t_stat = t_stat & 16'hC3FF;
                t_stat = t_stat | {2'b00, ev_err, 10'b0};
                if (ev_done != 0) t_int = t_int | 16'h8000 | {8'h00, ev_done, 4'h0};
                m_int = t_int; m_stat = t_stat;
                if (host_wr && host_addr == 3'd2) begin m_cfg1 = host_wdata; m_rdy = host_wdata[7]; end
                if (host_wr && host_addr == 3'd3) m_cfg2 = host_wdata;
                if (t_acc) m_cmd = host_wdata;
            end
            m_irq = t_irq;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        cold_rst = 0; warm_rst = 0; host_wr = 0; host_addr = 0;
        host_wdata = 0; ev_done = 0; ev_err = 0;
    endtask

    // called just after a negedge with inputs set; compares, then steps one edge
    task automatic tick(input string tag);
        #5;
        chk("R7 irq pin vs model", {15'b0, irq_o}, {15'b0, m_irq});
        chk("R10 rdy pin vs model", {15'b0, rdy_o}, {15'b0, m_rdy});
        chk("R8 accept vs model", {15'b0, cmd_accept}, {15'b0, m_accept()});
        chk(tag, rd_data, m_read(rd_addr));
        @(negedge clk);
        clear_in();
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #4;
        chk(tag, rd_data, exp);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
    endtask

    initial begin
        #4000000;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", {15'b0, irq_o}, 16'h0001);
        chk("R1 rdy after reset", {15'b0, rdy_o}, 16'h0001);
        rd_chk(3'd0, 16'h8080, "R1 int status");
        rd_chk(3'd1, 16'h0000, "R1 ctrl status");
        rd_chk(3'd2, 16'h40C0, "R1 cfg1");
        rd_chk(3'd3, 16'h0000, "R1 cfg2");
        rd_chk(3'd5, 16'h0000, "R11 unmapped read");

        // R8 command blocked while master pending
        wr(3'd4, 16'h00AA); rd_addr = 3'd4;
        #1 chk("R8 blocked accept", {15'b0, cmd_accept}, 16'h0000);
        tick("R8 blocked cmd");
        rd_chk(3'd4, 16'h0000, "R8 cmd unchanged");

        // R5 AND clear to zero, R7 irq falls one cycle later
        wr(3'd0, 16'h0000); tick("R5 clear");
        chk("R7 irq still old", {15'b0, irq_o}, 16'h0001);
        rd_chk(3'd0, 16'h0000, "R5 int cleared");
        chk("R7 irq low active-high", {15'b0, irq_o}, 16'h0000);

        // R8 accepted
        wr(3'd4, 16'h0094); rd_addr = 3'd4;
        #1 chk("R8 accept", {15'b0, cmd_accept}, 16'h0001);
        tick("R8 cmd");
        rd_chk(3'd4, 16'h0094, "R8 cmd stored");

        // R3 load done, R4 load error
        ev_done = 4'b1000; ev_err = 4'b1000; tick("R3 load");
        rd_chk(3'd0, 16'h8080, "R3 load done bits");
        rd_chk(3'd1, 16'h2000, "R4 load error bit");

        // R6 AND drops master -> errors cleared
        wr(3'd0, 16'h7FFF); tick("R6 drop master");
        rd_chk(3'd0, 16'h0080, "R5 AND result");
        rd_chk(3'd1, 16'h0000, "R6 errors cleared");

        // R3 program done with R4 command error, then clear with same-cycle error
        ev_done = 4'b0100; ev_err = 4'b0001; tick("R3 prog");
        rd_chk(3'd0, 16'h80C0, "R3 program done bits");
        rd_chk(3'd1, 16'h0400, "R4 command error bit");
        wr(3'd0, 16'h0000); ev_err = 4'b0100; tick("R6 clear with event");
        rd_chk(3'd1, 16'h1000, "R6 same-cycle error kept");

        // R6 master kept -> errors kept; erase done
        ev_done = 4'b0010; tick("R3 erase");
        rd_chk(3'd0, 16'h8020, "R3 erase done bits");
        wr(3'd0, 16'hFFDF); tick("R6 keep master");
        rd_chk(3'd0, 16'h8000, "R5 AND keeps master");
        rd_chk(3'd1, 16'h1000, "R6 errors kept");

        // R11 ctrl status read-only
        wr(3'd1, 16'hFFFF); tick("R11 write stat");
        rd_chk(3'd1, 16'h1000, "R11 stat unchanged");

        // R7 active-low polarity, R10 ready
        wr(3'd2, 16'h0080); tick("R7 pol write");
        rd_chk(3'd2, 16'h0080, "R9 cfg1 readback");
        chk("R7 irq low with master, active-low", {15'b0, irq_o}, 16'h0000);
        chk("R10 rdy high", {15'b0, rdy_o}, 16'h0001);
        wr(3'd0, 16'h0000); tick("R7 clear");
        rd_chk(3'd0, 16'h0000, "R5 cleared again");
        chk("R7 irq idle high active-low", {15'b0, irq_o}, 16'h0001);
        wr(3'd2, 16'h003F); tick("R9 write low bits");
        chk("R10 rdy low", {15'b0, rdy_o}, 16'h0000);
        rd_chk(3'd2, 16'h0020, "R9 cfg1 masked");
        wr(3'd3, 16'hBEEF); tick("R9 cfg2");
        rd_chk(3'd3, 16'hBEEF, "R9 cfg2 readback");

        // R2 warm reset, R1 cold strobe and both together
        ev_done = 4'b0001; tick("R3 reset done");
        rd_chk(3'd0, 16'h8010, "R3 reset done bits");
        ev_err = 4'b0010; tick("R4 erase err");
        warm_rst = 1; tick("R2 warm");
        rd_chk(3'd0, 16'h8010, "R2 warm int");
        rd_chk(3'd1, 16'h0000, "R2 warm stat");
        rd_chk(3'd2, 16'h40C0, "R2 warm cfg1");
        rd_chk(3'd3, 16'h0000, "R2 warm cfg2");
        rd_chk(3'd4, 16'h0000, "R2 warm cmd");
        chk("R2 rdy high", {15'b0, rdy_o}, 16'h0001);
        wr(3'd0, 16'h0000); tick("R5 clear");
        cold_rst = 1; tick("R1 cold strobe");
        rd_chk(3'd0, 16'h8080, "R1 cold strobe int");
        wr(3'd0, 16'h0000); tick("R5 clear");
        cold_rst = 1; warm_rst = 1; tick("R1 both resets");
        rd_chk(3'd0, 16'h8080, "R1 cold wins");

        // random traffic compared with model
        for (int n = 0; n < 1500; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if ($urandom_range(0, 2) == 0) wr(3'($urandom_range(0, 5)), 16'($urandom));
            if ($urandom_range(0, 3) == 0) ev_done = 4'($urandom);
            if ($urandom_range(0, 3) == 0) ev_err = 4'($urandom);
            if (r < 2) cold_rst = 1;
            else if (r < 5) warm_rst = 1;
            rd_addr = 3'($urandom_range(0, 5));
            tick("R3 R4 R5 R6 R11 random readback");
        end

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule